// File: doc/BRIEF.md
# Swizzled Vector Operand Fetch

This block sits between an instruction decoder and a four-lane arithmetic unit. It holds the register storage that such a datapath needs: sixteen input vectors, sixteen temporary vectors, a bank of constant vectors and thirty-two output component slots. Every vector has four components, and each component is an opaque 24-bit word. On each cycle the decoder presents a source-1 index, a source-2 index, a destination index and an operand-descriptor index. The block returns both source vectors at once, each routed through its own per-component selector, as combinational outputs. It also returns the resolved destination and the four-bit write mask.

The descriptor index reads a word from a small descriptor table, which software fills through a write port. That word holds the lane selectors for each source and the destination enable bits. When the write strobe is high, the result vector presented on `wr_data` is written into the destination storage at the next rising clock edge. A destination index names a starting component slot. Lane i of the result goes to that slot plus i, but only if enable bit i is set. Indices that fall outside the mapped windows raise an error flag, and the write is then dropped.

Input and constant vectors are loaded through a separate load port. Output slots can be read back one four-component register at a time through an observation port.

Top module: `vec_operand_fetch`

## Requirements
- R1: Source-1 index 0x00–0x0F reads input register idx. Index 0x10–0x1F reads temporary register idx−0x10. Index 0x20–0x7F reads constant register idx−0x20. Any index of 0x80 or above is invalid: it drives `err` high and gives an all-zero `src1_vec`.
- R2: Source-2 index 0x00–0x0F reads input register idx, and 0x10–0x1F reads temporary register idx−0x10. Source 2 has no path to constants.
- R3: Component c of every vector sits at bits [24c+23:24c], where c is 0 for x, 1 for y, 2 for z and 3 for w. Descriptor bits [5+2i:4+2i] choose which source-1 component drives lane i of `src1_vec`. Descriptor bits [13+2i:12+2i] do the same for `src2_vec`.
- R4: Destination index 0x00–0x1C is an output base slot: `dst_is_temp`=0 and `dst_slot`=idx. When the strobe is high, enabled lane i is written to output slot idx+i. Output register k, component j, is slot 4k+j and appears on `obs_vec` when `obs_reg`=k.
- R5: Destination index 0x40–0x7C is a temporary base slot: `dst_is_temp`=1 and `dst_slot`=idx−0x40. Enabled lane i is written to temporary slot idx−0x40+i, which is register slot/4, component slot mod 4.
- R6: Descriptor bits [3:0] are the lane enables and appear on `dst_mask` for a mapped destination. Slots of lanes whose enable bit is clear keep their old value.
- R7: Destination indices 0x1D–0x3F and 0x7D–0x7F are unmapped. For these, `err`=1 and `dst_mask`=0, and no storage changes.
- R8: Whenever `err` is high, a strobed write changes no temporary or output slot. This includes a write whose only fault is an invalid source-1 index.
- R9: When `dsc_we` is high, `dsc_data` is written to descriptor entry `dsc_addr` at the clock edge. Reads of the table are combinational.
- R10: When `ld_we` is high with `ld_to_const`=0, `ld_data` is written to input register `ld_idx[3:0]`. With `ld_to_const`=1, it is written to constant register `ld_idx`. A constant load with `ld_idx` of 96 or above is ignored.
- R11: After reset, all registers, slots and descriptor entries are zero.
- R12: Source reads are combinational from the indices. A value written at an edge is visible on the source outputs in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_we | input | 1 | Load strobe for input/constant storage |
| ld_to_const | input | 1 | 0 selects input storage, 1 selects constants |
| ld_idx | input | 7 | Register number for the load |
| ld_data | input | 96 | Vector to load |
| dsc_we | input | 1 | Descriptor table write strobe |
| dsc_addr | input | 5 | Descriptor entry to write |
| dsc_data | input | 20 | Descriptor word |
| src1_idx | input | 8 | Source-1 index |
| src2_idx | input | 5 | Source-2 index |
| dst_idx | input | 7 | Destination index |
| desc_idx | input | 5 | Descriptor entry used this cycle |
| wr_strobe | input | 1 | Commit `wr_data` to the destination at the edge |
| wr_data | input | 96 | Result vector, lane i at [24i+23:24i] |
| obs_reg | input | 3 | Output register to observe |
| obs_vec | output | 96 | Four slots of the observed output register |
| src1_vec | output | 96 | Swizzled source-1 vector |
| src2_vec | output | 96 | Swizzled source-2 vector |
| dst_is_temp | output | 1 | Destination is temporary storage |
| dst_slot | output | 6 | Destination base slot |
| dst_mask | output | 4 | Effective lane enables |
| err | output | 1 | Invalid source-1 or unmapped destination |

## Verification
The assertions assume that `wr_strobe`, `ld_we` and `dsc_we` are never unknown after reset. They also assume that the descriptor address fits the table depth, which always holds at the default power-of-two depth. The landing checks further assume that a descriptor entry and a destination index stay steady for the whole write cycle. The bench changes every input only at the falling edge and holds it for a full cycle. It raises the write strobe for exactly one cycle per write. Out-of-window indices are driven on purpose, so that the error-path properties are exercised rather than assumed away.

// File: rtl/vof_pkg.sv
package vof_pkg;
  localparam int CW         = 24;
  localparam int NLANE      = 4;
  localparam int VW         = CW * NLANE;
  localparam int NIN        = 16;
  localparam int NTMP       = 16;
  localparam int TMP_SLOTS  = NTMP * NLANE;
  localparam int OUT_SLOTS  = 32;
  localparam int OUT_REGS   = OUT_SLOTS / NLANE;
  localparam int DESC_W     = 20;
  localparam int MASK_LSB   = 0;
  localparam int SEL1_LSB   = 4;
  localparam int SEL2_LSB   = 12;

  typedef enum logic [1:0] {SP_NONE, SP_IN, SP_TMP, SP_CONST} src_space_e;
  typedef enum logic [1:0] {DK_NONE, DK_OUT, DK_TMP} dst_kind_e;

  typedef struct packed {
    src_space_e sp;
    logic [6:0] reg_no;
  } src_sel_t;

  typedef struct packed {
    dst_kind_e  kind;
    logic [5:0] slot;
  } dst_sel_t;

  // R1: three windows for source 1, everything above 0x7F is invalid
  function automatic src_sel_t dec_src1(input logic [7:0] idx);
    src_sel_t r;
    if (idx < 8'h10)      r = '{SP_IN,    {3'b000, idx[3:0]}};
    else if (idx < 8'h20) r = '{SP_TMP,   {3'b000, idx[3:0]}};
    else if (idx < 8'h80) r = '{SP_CONST, idx[6:0] - 7'h20};
    else                  r = '{SP_NONE,  7'd0};
    return r;
  endfunction

  // R4/R5/R7: destination windows, base slot per window
  function automatic dst_sel_t dec_dst(input logic [6:0] d);
    dst_sel_t r;
    if (d <= 7'h1C)                    r = '{DK_OUT,  d[5:0]};
    else if (d >= 7'h40 && d <= 7'h7C) r = '{DK_TMP,  d[5:0]};
    else                               r = '{DK_NONE, 6'd0};
    return r;
  endfunction

  // R3: lane i takes component sel[2i+1:2i] of the raw vector
  function automatic logic [VW-1:0] swizzle(input logic [VW-1:0] v,
                                            input logic [2*NLANE-1:0] sel);
    logic [VW-1:0] o;
    for (int i = 0; i < NLANE; i++)
      o[i*CW +: CW] = v[32'(sel[2*i +: 2]) * CW +: CW];
    return o;
  endfunction
endpackage

// File: rtl/vof_desc_table.sv
module vof_desc_table import vof_pkg::*; #(
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DESC_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DESC_W-1:0] rdata
);
  logic [DESC_W-1:0] mem [DEPTH];

  // R9, R11
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  p_desc_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (mem[$past(waddr)] == $past(wdata)))
    else $error("descriptor write lost");
endmodule

// File: rtl/vof_swizzle.sv
module vof_swizzle import vof_pkg::*; (
  input  logic [VW-1:0]      raw,
  input  logic [2*NLANE-1:0] sel,
  output logic [VW-1:0]      vec
);
  assign vec = swizzle(raw, sel);
endmodule

// File: rtl/vec_operand_fetch.sv
module vec_operand_fetch import vof_pkg::*; #(
  parameter int N_CONST    = 96,
  parameter int DESC_DEPTH = 32,
  localparam int DAW       = $clog2(DESC_DEPTH),
  localparam int CIW       = $clog2(N_CONST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_we,
  input  logic              ld_to_const,
  input  logic [6:0]        ld_idx,
  input  logic [VW-1:0]     ld_data,
  input  logic              dsc_we,
  input  logic [DAW-1:0]    dsc_addr,
  input  logic [DESC_W-1:0] dsc_data,
  input  logic [7:0]        src1_idx,
  input  logic [4:0]        src2_idx,
  input  logic [6:0]        dst_idx,
  input  logic [DAW-1:0]    desc_idx,
  input  logic              wr_strobe,
  input  logic [VW-1:0]     wr_data,
  input  logic [2:0]        obs_reg,
  output logic [VW-1:0]     obs_vec,
  output logic [VW-1:0]     src1_vec,
  output logic [VW-1:0]     src2_vec,
  output logic              dst_is_temp,
  output logic [5:0]        dst_slot,
  output logic [3:0]        dst_mask,
  output logic              err
);
  localparam logic [6:0] CONST_LIM = 7'(N_CONST);

  logic [VW-1:0] in_r    [NIN];
  logic [VW-1:0] const_r [N_CONST];
  logic [CW-1:0] tmp_c   [TMP_SLOTS];
  logic [CW-1:0] out_c   [OUT_SLOTS];

  // R10: load port for inputs and constants
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NIN; k++)     in_r[k]    <= '0;
      for (int k = 0; k < N_CONST; k++) const_r[k] <= '0;
    end else if (ld_we) begin
      if (!ld_to_const)            in_r[ld_idx[3:0]]       <= ld_data;
      else if (ld_idx < CONST_LIM) const_r[ld_idx[CIW-1:0]] <= ld_data;
    end
  end

  // descriptor table (R9)
  logic [DESC_W-1:0] desc_w;
  vof_desc_table #(.DEPTH(DESC_DEPTH)) u_desc (
    .clk(clk), .rst_n(rst_n), .we(dsc_we), .waddr(dsc_addr),
    .wdata(dsc_data), .raddr(desc_idx), .rdata(desc_w));

  // temporary registers gathered as vectors, plus a flat view for checks
  logic [VW-1:0]           tmp_vec  [NTMP];
  logic [TMP_SLOTS*CW-1:0] tmp_flat;
  logic [OUT_SLOTS*CW-1:0] out_flat;
  always_comb begin
    for (int r = 0; r < NTMP; r++)
      for (int i = 0; i < NLANE; i++)
        tmp_vec[r][i*CW +: CW] = tmp_c[r*NLANE + i];
    for (int s = 0; s < TMP_SLOTS; s++) tmp_flat[s*CW +: CW] = tmp_c[s];
    for (int s = 0; s < OUT_SLOTS; s++) out_flat[s*CW +: CW] = out_c[s];
  end

  // source decode (R1, R2, R12)
  src_sel_t      s1;
  logic          s1_bad;
  logic [VW-1:0] raw1, raw2;
  assign s1     = dec_src1(src1_idx);
  assign s1_bad = (s1.sp == SP_NONE) || (s1.sp == SP_CONST && s1.reg_no >= CONST_LIM);

  always_comb begin
    raw1 = '0;
    case (s1.sp)
      SP_IN:    raw1 = in_r[s1.reg_no[3:0]];
      SP_TMP:   raw1 = tmp_vec[s1.reg_no[3:0]];
      SP_CONST: if (!s1_bad) raw1 = const_r[s1.reg_no[CIW-1:0]];
      default:  raw1 = '0;
    endcase
  end
  assign raw2 = src2_idx[4] ? tmp_vec[src2_idx[3:0]] : in_r[src2_idx[3:0]];

  // R3: one swizzle network per source
  logic [2*NLANE-1:0] sel_pair [2];
  logic [VW-1:0]      raw_pair [2];
  logic [VW-1:0]      vec_pair [2];
  assign sel_pair[0] = desc_w[SEL1_LSB +: 2*NLANE];
  assign sel_pair[1] = desc_w[SEL2_LSB +: 2*NLANE];
  assign raw_pair[0] = raw1;
  assign raw_pair[1] = raw2;
  for (genvar g = 0; g < 2; g++) begin : g_swz
    vof_swizzle u_swz (.raw(raw_pair[g]), .sel(sel_pair[g]), .vec(vec_pair[g]));
  end
  assign src1_vec = vec_pair[0];
  assign src2_vec = vec_pair[1];

  // destination decode (R4-R8)
  dst_sel_t   dst;
  logic       commit;
  assign dst         = dec_dst(dst_idx);
  assign dst_is_temp = (dst.kind == DK_TMP);
  assign dst_slot    = dst.slot;
  assign dst_mask    = (dst.kind == DK_NONE) ? 4'b0000 : desc_w[MASK_LSB +: NLANE];
  assign err         = s1_bad || (dst.kind == DK_NONE);
  assign commit      = wr_strobe && !err;

  logic          tmp_we [TMP_SLOTS];
  logic [CW-1:0] tmp_wd [TMP_SLOTS];
  logic          out_we [OUT_SLOTS];
  logic [CW-1:0] out_wd [OUT_SLOTS];
  always_comb begin
    for (int s = 0; s < TMP_SLOTS; s++) begin tmp_we[s] = 1'b0; tmp_wd[s] = '0; end
    for (int s = 0; s < OUT_SLOTS; s++) begin out_we[s] = 1'b0; out_wd[s] = '0; end
    for (int i = 0; i < NLANE; i++) begin
      if (commit && dst_mask[i]) begin
        if (dst.kind == DK_TMP) begin
          tmp_we[dst.slot + 6'(i)] = 1'b1;
          tmp_wd[dst.slot + 6'(i)] = wr_data[i*CW +: CW];
        end else begin
          out_we[dst.slot[4:0] + 5'(i)] = 1'b1;
          out_wd[dst.slot[4:0] + 5'(i)] = wr_data[i*CW +: CW];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < TMP_SLOTS; s++) tmp_c[s] <= '0;
      for (int s = 0; s < OUT_SLOTS; s++) out_c[s] <= '0;
    end else begin
      for (int s = 0; s < TMP_SLOTS; s++) if (tmp_we[s]) tmp_c[s] <= tmp_wd[s];
      for (int s = 0; s < OUT_SLOTS; s++) if (out_we[s]) out_c[s] <= out_wd[s];
    end
  end

  // R4: observation of one output register
  always_comb
    for (int j = 0; j < NLANE; j++)
      obs_vec[j*CW +: CW] = out_c[{obs_reg, 2'(j)}];

  // named taps for the assertions
  logic [5:0]    nxt_slot;
  logic [CW-1:0] tmp_at_base, tmp_at_next;
  assign nxt_slot    = dst.slot + 6'd1;
  assign tmp_at_base = tmp_c[dst.slot];
  assign tmp_at_next = tmp_c[nxt_slot];

  p_err_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && err) |=> ($stable(tmp_flat) && $stable(out_flat)))
    else $error("write leaked through an error");

  p_tmp_land_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !err && dst_is_temp && dst_mask[0])
      |=> (tmp_c[$past(dst.slot)] == $past(wr_data[CW-1:0])))
    else $error("temporary lane 0 not written");

  p_out_land_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !err && !dst_is_temp && dst_mask[0])
      |=> (out_c[$past(dst.slot[4:0])] == $past(wr_data[CW-1:0])))
    else $error("output lane 0 not written");

  p_mask_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !err && dst_is_temp && !dst_mask[1])
      |=> (tmp_c[$past(nxt_slot)] == $past(tmp_at_next)))
    else $error("disabled lane changed");

  p_base_change_only_enabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && dst_is_temp && !dst_mask[0])
      |=> (tmp_c[$past(dst.slot)] == $past(tmp_at_base)))
    else $error("disabled base lane changed");
endmodule

// File: tb/vec_operand_fetch_bench.sv
module vec_operand_fetch_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_we = 0, ld_to_const = 0;
  logic [6:0]  ld_idx = '0;
  logic [95:0] ld_data = '0;
  logic        dsc_we = 0;
  logic [4:0]  dsc_addr = '0;
  logic [19:0] dsc_data = '0;
  logic [7:0]  src1_idx = '0;
  logic [4:0]  src2_idx = '0;
  logic [6:0]  dst_idx = '0;
  logic [4:0]  desc_idx = '0;
  logic        wr_strobe = 0;
  logic [95:0] wr_data = '0;
  logic [2:0]  obs_reg = '0;
  logic [95:0] obs_vec, src1_vec, src2_vec;
  logic        dst_is_temp, err;
  logic [5:0]  dst_slot;
  logic [3:0]  dst_mask;

  vec_operand_fetch u_vec_operand_fetch (.*);

  always #(CLK_P/2) clk = ~clk;

  // bench-side model of the storage
  logic [95:0] m_in [16];
  logic [95:0] m_const [96];
  logic [23:0] m_tmp [64];
  logic [23:0] m_out [32];
  logic [19:0] m_desc [32];

  typedef struct { string req; int kind; logic [95:0] exp; } item_t;
  item_t sb[$];
  int errors = 0, checks = 0;
  bit done = 0;

  function automatic logic [95:0] pat(int seed);
    logic [95:0] v;
    for (int i = 0; i < 4; i++) v[i*24 +: 24] = 24'(32'hA00000 + seed * 256 + i * 17);
    return v;
  endfunction

  function automatic logic [95:0] m_treg(int r);
    logic [95:0] v;
    for (int i = 0; i < 4; i++) v[i*24 +: 24] = m_tmp[r*4 + i];
    return v;
  endfunction

  function automatic logic [95:0] m_oreg(int r);
    logic [95:0] v;
    for (int i = 0; i < 4; i++) v[i*24 +: 24] = m_out[r*4 + i];
    return v;
  endfunction

  function automatic logic [95:0] m_pick(logic [95:0] raw, int d, int base);
    logic [95:0] v;
    for (int i = 0; i < 4; i++) begin
      int c;
      c = int'(m_desc[d][base + 2*i +: 2]);
      v[i*24 +: 24] = raw[c*24 +: 24];
    end
    return v;
  endfunction

  function automatic logic [95:0] exp_src1(int idx, int d);
    logic [95:0] raw;
    if (idx < 16)       raw = m_in[idx];
    else if (idx < 32)  raw = m_treg(idx - 16);
    else if (idx < 128) raw = m_const[idx - 32];
    else                raw = '0;
    return m_pick(raw, d, 4);
  endfunction

  function automatic logic [95:0] exp_src2(int idx, int d);
    return m_pick((idx < 16) ? m_in[idx] : m_treg(idx - 16), d, 12);
  endfunction

  task automatic push(int kind, string req, logic [95:0] exp);
    item_t it;
    it.req = req; it.kind = kind; it.exp = exp;
    sb.push_back(it);
  endtask

  // monitor: compares a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (sb.size() > 0) begin
        item_t it;
        logic [95:0] got;
        it = sb.pop_front();
        case (it.kind)
          0: got = src1_vec;
          1: got = src2_vec;
          2: got = {95'd0, err};
          3: got = obs_vec;
          4: got = {92'd0, dst_mask};
          5: got = {90'd0, dst_slot};
          default: got = {95'd0, dst_is_temp};
        endcase
        checks++;
        if (got !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, got, it.exp);
        end
      end
    end
  end

  task automatic set_rd(int s1, int s2, int d, int dsc, int ob);
    src1_idx = 8'(s1); src2_idx = 5'(s2); dst_idx = 7'(d);
    desc_idx = 5'(dsc); obs_reg = 3'(ob);
  endtask

  task automatic load(bit to_const, int idx, logic [95:0] v);
    @(negedge clk);
    ld_we = 1; ld_to_const = to_const; ld_idx = 7'(idx); ld_data = v;
    if (!to_const) m_in[idx % 16] = v;
    else if (idx < 96) m_const[idx] = v;
    @(negedge clk);
    ld_we = 0;
  endtask

  task automatic wdesc(int a, logic [19:0] w);
    @(negedge clk);
    dsc_we = 1; dsc_addr = 5'(a); dsc_data = w; m_desc[a] = w;
    @(negedge clk);
    dsc_we = 0;
  endtask

  // one strobed write; model updated from the rules
  task automatic wr(int d, int dsc, int s1, logic [95:0] v, string req);
    bit bad, is_out, is_tmp;
    @(negedge clk);
    set_rd(s1, 0, d, dsc, 0);
    wr_data = v; wr_strobe = 1;
    is_out = (d <= 8'h1C);
    is_tmp = (d >= 8'h40 && d <= 8'h7C);
    bad = (s1 >= 8'h80) || !(is_out || is_tmp);
    push(2, req, {95'd0, bad});
    if (!bad)
      for (int i = 0; i < 4; i++)
        if (m_desc[dsc][i]) begin
          if (is_tmp) m_tmp[d - 8'h40 + i] = v[i*24 +: 24];
          else        m_out[d + i] = v[i*24 +: 24];
        end
    @(negedge clk);
    wr_strobe = 0;
  endtask

  initial begin
    for (int k = 0; k < 16; k++) m_in[k] = '0;
    for (int k = 0; k < 96; k++) m_const[k] = '0;
    for (int k = 0; k < 64; k++) m_tmp[k] = '0;
    for (int k = 0; k < 32; k++) m_out[k] = '0;
    for (int k = 0; k < 32; k++) m_desc[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R11: reset state
    @(negedge clk);
    set_rd(8'h10, 5'h1F, 8'h40, 0, 7);
    push(0, "R11 temp reads zero", '0);
    push(1, "R11 src2 zero", '0);
    push(3, "R11 outputs zero", '0);
    push(4, "R11 descriptor mask zero", '0);
    push(2, "R11 no error", '0);

    // R10: loads
    for (int k = 0; k < 16; k++) load(0, k, pat(k));
    load(1, 0, pat(40));
    load(1, 50, pat(41));
    load(1, 95, pat(42));
    load(1, 96, pat(43));
    load(1, 127, pat(44));

    // R9: descriptors
    wdesc(0, {8'hE4, 8'hE4, 4'hF});
    wdesc(1, {8'hFF, 8'h1B, 4'b0101});
    wdesc(2, {8'h00, 8'hE4, 4'h0});
    wdesc(3, {8'h4E, 8'hE4, 4'b1000});

    // R1 windows, identity swizzle
    @(negedge clk);
    set_rd(8'h03, 5'h05, 8'h40, 0, 0);
    push(0, "R1 input window", exp_src1(8'h03, 0));
    push(1, "R2 input window", exp_src2(5'h05, 0));
    push(2, "R1 valid index no error", '0);
    push(4, "R6 mask passes for mapped dest", 96'hF);
    @(negedge clk);
    set_rd(8'h20, 0, 8'h40, 0, 0);
    push(0, "R10 constant 0 via R1", exp_src1(8'h20, 0));
    @(negedge clk);
    set_rd(8'h52, 0, 8'h40, 0, 0);
    push(0, "R10 constant 50 via R1", exp_src1(8'h52, 0));
    @(negedge clk);
    set_rd(8'h7F, 0, 8'h40, 0, 0);
    push(0, "R10 constant 95 kept after ignored loads", pat(42));
    @(negedge clk);
    set_rd(8'h80, 0, 8'h40, 0, 0);
    push(0, "R1 invalid gives zero", '0);
    push(2, "R1 invalid raises err", 96'd1);
    @(negedge clk);
    set_rd(8'hFF, 0, 8'h40, 0, 0);
    push(2, "R1 top index invalid", 96'd1);

    // R3: swizzle
    @(negedge clk);
    set_rd(8'h03, 5'h02, 8'h40, 1, 0);
    push(0, "R3 reversed src1", exp_src1(8'h03, 1));
    push(1, "R3 broadcast w src2", exp_src2(5'h02, 1));
    push(4, "R6 mask 0101", 96'h5);
    @(negedge clk);
    set_rd(8'h07, 5'h07, 8'h40, 3, 0);
    push(1, "R3 src2 zwxy", exp_src2(5'h07, 3));

    // R5/R12: temporary writes
    wr(8'h40, 0, 8'h01, pat(60), "R5 aligned write no err");
    @(negedge clk);
    set_rd(8'h10, 5'h10, 8'h40, 0, 0);
    push(0, "R12 temp0 visible on src1", m_treg(0));
    push(1, "R2 temp0 via src2", exp_src2(5'h10, 0));
    wr(8'h45, 0, 8'h01, pat(61), "R5 unaligned write no err");
    @(negedge clk);
    set_rd(8'h11, 5'h12, 8'h45, 0, 0);
    push(0, "R5 temp1 after split write", m_treg(1));
    push(1, "R5 temp2 lane0 after split write", m_treg(2));
    push(5, "R5 dst_slot", 96'h05);
    push(6, "R5 dst_is_temp", 96'd1);

    // R6: masked lanes keep old value
    wr(8'h48, 1, 8'h01, pat(62), "R6 masked write no err");
    @(negedge clk);
    set_rd(8'h12, 5'h1F, 8'h48, 0, 0);
    push(0, "R6 temp2 lanes 1,3 kept", m_treg(2));
    push(1, "R2 temp15 untouched", m_treg(15));
    wr(8'h7C, 2, 8'h01, pat(63), "R6 zero mask write");
    @(negedge clk);
    set_rd(8'h1F, 0, 8'h7C, 0, 0);
    push(0, "R6 zero mask leaves temp15", m_treg(15));
    wr(8'h7C, 0, 8'h01, pat(64), "R5 last temp slot");
    @(negedge clk);
    set_rd(8'h1F, 0, 8'h7C, 0, 0);
    push(0, "R5 temp15 written", m_treg(15));

    // R4: outputs
    wr(8'h00, 0, 8'h01, pat(70), "R4 output write no err");
    wr(8'h1C, 0, 8'h01, pat(71), "R4 top output write no err");
    @(negedge clk);
    set_rd(0, 0, 8'h1C, 0, 0);
    push(3, "R4 output reg0", m_oreg(0));
    push(5, "R4 dst_slot", 96'h1C);
    push(6, "R4 not temp", 96'd0);
    @(negedge clk);
    set_rd(0, 0, 8'h02, 0, 7);
    push(3, "R4 output reg7", m_oreg(7));
    wr(8'h06, 3, 8'h01, pat(72), "R4 partial output write");
    @(negedge clk);
    set_rd(0, 0, 8'h06, 0, 2);
    push(3, "R4 output reg2 lane w only", m_oreg(2));

    // R7/R8: unmapped and invalid
    wr(8'h1D, 0, 8'h01, pat(80), "R7 unmapped 0x1D err");
    wr(8'h3F, 0, 8'h01, pat(81), "R7 unmapped 0x3F err");
    wr(8'h7D, 0, 8'h01, pat(82), "R7 unmapped 0x7D err");
    @(negedge clk);
    set_rd(8'h1F, 0, 8'h3C, 0, 7);
    push(3, "R7 output reg7 unchanged", m_oreg(7));
    push(0, "R7 temp15 unchanged", m_treg(15));
    push(4, "R7 mask zero when unmapped", '0);
    wr(8'h40, 0, 8'h90, pat(83), "R8 bad src1 err");
    @(negedge clk);
    set_rd(8'h10, 0, 8'h40, 0, 0);
    push(0, "R8 temp0 kept", m_treg(0));

    repeat (3) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule